// File: doc/BRIEF.md
# Banked Register and Bit-Addressable Data Store

This block is the 256-address internal data store of an 8-bit microcontroller core. The lower half is a 128-byte RAM held in the block. It contains four banks of eight working registers, a 16-byte region whose bits can be addressed one by one, and general storage. The upper half is not stored here. Byte and bit accesses to that half are forwarded through a window to special-function registers that live elsewhere in the core.

The core reaches the store through three independent ports that all act in the same cycle. A byte port takes a full 8-bit address. A register port takes a 3-bit register index plus a 2-bit bank select; the bank select comes from the status word, which is kept outside this block. A bit port reads, sets or clears a single bit selected by an 8-bit bit address. That bit address maps either into the bit region of RAM or into any special-function register whose address is a multiple of eight. Reads are combinational from the stored state. Writes take effect at the next rising clock edge, and a bit write is done as a read-modify-write of its byte within that one cycle.

Top module: `bank_bit_dmem`

## Requirements
- R1: A synchronous active-low reset clears every RAM byte (addresses 00h to 7Fh) to zero.
- R2: A byte write to an address below 80h stores the data at the next rising edge, and a byte read of that address returns it combinationally.
- R3: The register port addresses RAM byte bank_sel*8 + reg_idx for both reads and writes, with bank_sel in 0..3 and reg_idx in 0..7.
- R4: With bank_sel = 0, register n and byte address n are the same location.
- R5: A bit address below 80h selects bit position bit_addr[2:0] of RAM byte 20h + bit_addr[6:3]. bit_wval = 1 sets that bit, bit_wval = 0 clears it, and bit_rdata returns it. For example, bit 25h is bit 5 of byte 24h.
- R6: A bit write changes only its selected bit. A byte write into 20h..2Fh updates all eight bit addresses of that byte together.
- R7: A byte access at 80h or above goes out on the byte-side window port, with the same address and data. Write enable is raised only for writes. Such an access does not change RAM, and a read of it returns sfr_byte_rdata.
- R8: A bit address of 80h or above selects the register at bit_addr & F8h, bit bit_addr[2:0]. A bit write puts sfr_bit_rdata, with only that bit replaced, onto the bit-side window port in the same cycle.
- R9: When a byte write and a bit write hit the same RAM byte in one cycle, the stored byte is the byte data with the bit write applied on top.
- R10: When a byte write and a register write hit the same RAM byte in one cycle, the register data is stored.
- R11: When a byte write and a bit write hit the same window register in one cycle, only the bit-side port writes. It carries the byte data with the bit applied, and both window write enables are never high for one address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_we | input | 1 | Byte port write enable |
| byte_addr | input | 8 | Byte port address |
| byte_wdata | input | 8 | Byte port write data |
| byte_rdata | output | 8 | Byte port read data |
| reg_we | input | 1 | Register port write enable |
| reg_idx | input | 3 | Register index within bank |
| bank_sel | input | 2 | Active register bank |
| reg_wdata | input | 8 | Register port write data |
| reg_rdata | output | 8 | Register port read data |
| bit_we | input | 1 | Bit port write enable |
| bit_addr | input | 8 | Bit address |
| bit_wval | input | 1 | Value written to the addressed bit |
| bit_rdata | output | 1 | Value of the addressed bit |
| sfr_byte_addr | output | 8 | Window address for byte accesses |
| sfr_byte_we | output | 1 | Window byte write strobe |
| sfr_byte_wdata | output | 8 | Window byte write data |
| sfr_byte_rdata | input | 8 | Window byte read data |
| sfr_bit_addr | output | 8 | Window register holding the addressed bit |
| sfr_bit_we | output | 1 | Window bit-merge write strobe |
| sfr_bit_wdata | output | 8 | Merged byte for the bit write |
| sfr_bit_rdata | input | 8 | Window read data for the bit-side register |

## Verification
Register writes are made in all four banks with distinct indices. Only the bank*8 + index mapping puts each value at the byte address that is then read back, so a swapped or truncated bank field lands data elsewhere. Bit writes at the first, last and middle bit addresses of the RAM region, and at window addresses, check the split of the bit address into byte and position. A byte overwrite of the bit region, read back bit by bit, checks the mapping in the other direction. Same-cycle collisions of byte with register writes, and of byte with bit writes in both RAM and the window, fix the priority order that a single-port test cannot see.

// File: rtl/bbd_pkg.sv
// Shared constants and types for the banked, bit-addressable data store.
// Assumes an 8-bit datapath with the upper half of the address space
// forwarded to an external register window.
package bbd_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 8;
    localparam int IDX_W     = 3;
    localparam int BANK_W    = 2;
    localparam int POS_W     = $clog2(DATA_W);
    localparam int RAM_AW    = ADDR_W - 1;
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam logic [ADDR_W-1:0] BIT_BASE = 8'h20;

    // Decoded target of a bit address.
    typedef struct packed {
        logic              in_sfr;
        logic [ADDR_W-1:0] byte_addr;
        logic [POS_W-1:0]  pos;
    } bit_tgt_t;
endpackage

// File: rtl/bbd_bank_map.sv
// Register-index relocation: turns a bank select and a register index
// into a RAM byte index. Assumes banks of 2**IDX_W registers packed from
// address zero upward.
module bbd_bank_map #(
    parameter int IDX_W  = bbd_pkg::IDX_W,
    parameter int BANK_W = bbd_pkg::BANK_W,
    parameter int RAM_AW = bbd_pkg::RAM_AW
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [BANK_W-1:0] bank,
    output logic [RAM_AW-1:0] ram_idx
);
    localparam int PAD = RAM_AW - IDX_W - BANK_W;

    // Bank forms the upper bits of the register address.
    assign ram_idx = {{PAD{1'b0}}, bank, idx};
endmodule

// File: rtl/bbd_bit_map.sv
// Bit-address decoder: splits a bit address into the byte that holds it
// and its bit position. Low bit addresses map into the RAM bit region,
// high ones onto every eighth window register.
module bbd_bit_map
    import bbd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE = BIT_BASE
) (
    input  logic [ADDR_W-1:0] bit_addr,
    output bit_tgt_t          tgt
);
    // Select between RAM bit region and window register alignment.
    always_comb begin
        tgt.in_sfr = bit_addr[ADDR_W-1];
        tgt.pos    = bit_addr[POS_W-1:0];
        if (bit_addr[ADDR_W-1])
            tgt.byte_addr = {bit_addr[ADDR_W-1:POS_W], {POS_W{1'b0}}};
        else
            tgt.byte_addr = BASE + {{(POS_W+1){1'b0}}, bit_addr[ADDR_W-2:POS_W]};
    end
endmodule

// File: rtl/bbd_ram.sv
// The 128-byte RAM array with three write ports merged per byte.
// Merge order per cell: byte data, then register data, then bit update.
// Reads are combinational. Assumes synchronous active-low reset to zero.
module bbd_ram #(
    parameter int DATA_W = bbd_pkg::DATA_W,
    parameter int RAM_AW = bbd_pkg::RAM_AW,
    parameter int POS_W  = bbd_pkg::POS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [RAM_AW-1:0] byte_idx,
    input  logic [DATA_W-1:0] byte_wdata,
    input  logic              reg_we,
    input  logic [RAM_AW-1:0] reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              bit_we,
    input  logic [RAM_AW-1:0] bit_idx,
    input  logic [POS_W-1:0]  bit_pos,
    input  logic              bit_val,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] rd_reg,
    output logic [DATA_W-1:0] rd_bit_byte
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DEPTH-1:0][DATA_W-1:0] mem;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [RAM_AW-1:0] CELL = RAM_AW'(i);
        logic [DATA_W-1:0] q;
        logic [DATA_W-1:0] nxt;

        // Priority merge of the three write sources for this byte.
        always_comb begin
            nxt = q;
            if (byte_we && byte_idx == CELL) nxt = byte_wdata;
            if (reg_we && reg_idx == CELL)   nxt = reg_wdata;
            if (bit_we && bit_idx == CELL)   nxt[bit_pos] = bit_val;
        end

        // Storage register for this byte, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end

        assign mem[i] = q;
    end

    // Combinational read ports.
    assign rd_byte     = mem[byte_idx];
    assign rd_reg      = mem[reg_idx];
    assign rd_bit_byte = mem[bit_idx];

    logic [DATA_W-1:0] bit_mask;
    assign bit_mask = DATA_W'(1) << bit_pos;

    // R5: the addressed bit takes the written value.
    a_r5_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        bit_we |=> mem[$past(bit_idx)][$past(bit_pos)] == $past(bit_val));

    // R6: other bits of the byte are kept when nothing else writes it.
    a_r6_bit_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && !(byte_we && byte_idx == bit_idx) && !(reg_we && reg_idx == bit_idx))
        |=> ((mem[$past(bit_idx)] ^ $past(mem[bit_idx])) & ~$past(bit_mask)) == '0);

    // R2: an uncontested byte write is stored.
    a_r2_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !(reg_we && reg_idx == byte_idx) && !(bit_we && bit_idx == byte_idx))
        |=> mem[$past(byte_idx)] == $past(byte_wdata));

    // R10: a register write is stored, also over a byte write.
    a_r10_reg_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !(bit_we && bit_idx == reg_idx))
        |=> mem[$past(reg_idx)] == $past(reg_wdata));
endmodule

// File: rtl/bbd_sfr_port.sv
// Window forwarding for the upper address half. The byte side is passed
// through. The bit side reads the target register, replaces one bit and
// writes it back in the same cycle. A same-address byte write is folded
// into the bit side so that only one strobe fires.
module bbd_sfr_port
    import bbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_wdata,
    input  logic              bit_we,
    input  bit_tgt_t          tgt,
    input  logic              bit_val,
    input  logic [DATA_W-1:0] sfr_bit_rdata,
    output logic              sfr_byte_we,
    output logic              sfr_bit_we,
    output logic [DATA_W-1:0] sfr_bit_wdata
);
    logic              byte_hit;
    logic              bit_hit;
    logic              same;
    logic [DATA_W-1:0] base;

    // Window hit detection and same-register collision.
    always_comb begin
        byte_hit = byte_we && byte_addr[ADDR_W-1];
        bit_hit  = bit_we && tgt.in_sfr;
        same     = byte_hit && bit_hit && (byte_addr == tgt.byte_addr);
    end

    // Read-modify-write merge for the bit side.
    always_comb begin
        base               = same ? byte_wdata : sfr_bit_rdata;
        sfr_bit_wdata      = base;
        sfr_bit_wdata[tgt.pos] = bit_val;
    end

    assign sfr_bit_we  = bit_hit;
    assign sfr_byte_we = byte_hit && !same;

    logic [DATA_W-1:0] pos_mask;
    assign pos_mask = DATA_W'(1) << tgt.pos;

    // R8: without a colliding byte write, only the addressed bit may differ.
    a_r8_rmw_keeps_others: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_bit_we && !(byte_we && byte_addr == tgt.byte_addr))
        |-> ((sfr_bit_wdata ^ sfr_bit_rdata) & ~pos_mask) == '0);

    // R11: the two window strobes never target one register together.
    a_r11_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_byte_we && sfr_bit_we) |-> byte_addr != tgt.byte_addr);
endmodule

// File: rtl/bank_bit_dmem.sv
// Internal data store top: 128-byte RAM with banked register access and
// bit addressing, plus forwarding of the upper 128 addresses to an
// external register window. Assumes the bank select is held outside.
module bank_bit_dmem
    import bbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_we,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic [DATA_W-1:0] byte_wdata,
    output logic [DATA_W-1:0] byte_rdata,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bit_we,
    input  logic [ADDR_W-1:0] bit_addr,
    input  logic              bit_wval,
    output logic              bit_rdata,
    output logic [ADDR_W-1:0] sfr_byte_addr,
    output logic              sfr_byte_we,
    output logic [DATA_W-1:0] sfr_byte_wdata,
    input  logic [DATA_W-1:0] sfr_byte_rdata,
    output logic [ADDR_W-1:0] sfr_bit_addr,
    output logic              sfr_bit_we,
    output logic [DATA_W-1:0] sfr_bit_wdata,
    input  logic [DATA_W-1:0] sfr_bit_rdata
);
    logic [RAM_AW-1:0] reg_ram_idx;
    bit_tgt_t          tgt;
    logic [DATA_W-1:0] ram_rd_byte;
    logic [DATA_W-1:0] ram_rd_bit;
    logic              ram_byte_we;
    logic              ram_bit_we;

    bbd_bank_map u_bank (
        .idx     (reg_idx),
        .bank    (bank_sel),
        .ram_idx (reg_ram_idx)
    );

    bbd_bit_map u_bitmap (
        .bit_addr (bit_addr),
        .tgt      (tgt)
    );

    // RAM write enables only for the lower address half.
    assign ram_byte_we = byte_we && !byte_addr[ADDR_W-1];
    assign ram_bit_we  = bit_we && !tgt.in_sfr;

    bbd_ram u_ram (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_we     (ram_byte_we),
        .byte_idx    (byte_addr[RAM_AW-1:0]),
        .byte_wdata  (byte_wdata),
        .reg_we      (reg_we),
        .reg_idx     (reg_ram_idx),
        .reg_wdata   (reg_wdata),
        .bit_we      (ram_bit_we),
        .bit_idx     (tgt.byte_addr[RAM_AW-1:0]),
        .bit_pos     (tgt.pos),
        .bit_val     (bit_wval),
        .rd_byte     (ram_rd_byte),
        .rd_reg      (reg_rdata),
        .rd_bit_byte (ram_rd_bit)
    );

    bbd_sfr_port u_sfr (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_we       (byte_we),
        .byte_addr     (byte_addr),
        .byte_wdata    (byte_wdata),
        .bit_we        (bit_we),
        .tgt           (tgt),
        .bit_val       (bit_wval),
        .sfr_bit_rdata (sfr_bit_rdata),
        .sfr_byte_we   (sfr_byte_we),
        .sfr_bit_we    (sfr_bit_we),
        .sfr_bit_wdata (sfr_bit_wdata)
    );

    // Window addressing and read-data selection.
    assign sfr_byte_addr  = byte_addr;
    assign sfr_byte_wdata = byte_wdata;
    assign sfr_bit_addr   = tgt.byte_addr;
    assign byte_rdata     = byte_addr[ADDR_W-1] ? sfr_byte_rdata : ram_rd_byte;
    assign bit_rdata      = tgt.in_sfr ? sfr_bit_rdata[tgt.pos] : ram_rd_bit[tgt.pos];

    // R4: in bank 0 a register read equals the byte read of its index.
    a_r4_bank0_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel == '0 && byte_addr == ADDR_W'(reg_idx)) |-> reg_rdata == byte_rdata);

    // R7: window byte strobe only for upper-half writes.
    a_r7_window_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_byte_we |-> (byte_we && byte_addr[ADDR_W-1]));
endmodule

// File: tb/bank_bit_dmem_test.sv
module bank_bit_dmem_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    // Vector: kind(0 byte,1 reg,2 bit) | bank | addr | wdata | check addr | expected byte
    localparam logic [0:NV-1][35:0] VEC = {
        {2'd0, 2'd0, 8'h30, 8'hA5, 8'h30, 8'hA5},  // R2
        {2'd0, 2'd0, 8'h7F, 8'h3C, 8'h7F, 8'h3C},  // R2
        {2'd1, 2'd0, 8'h02, 8'h11, 8'h02, 8'h11},  // R3 R4
        {2'd1, 2'd3, 8'h07, 8'h77, 8'h1F, 8'h77},  // R3
        {2'd1, 2'd1, 8'h00, 8'h81, 8'h08, 8'h81},  // R3
        {2'd1, 2'd2, 8'h05, 8'h55, 8'h15, 8'h55},  // R3
        {2'd2, 2'd0, 8'h25, 8'h01, 8'h24, 8'h20},  // R5
        {2'd2, 2'd0, 8'h00, 8'h01, 8'h20, 8'h01},  // R5
        {2'd2, 2'd0, 8'h7F, 8'h01, 8'h2F, 8'h80},  // R5
        {2'd0, 2'd0, 8'h20, 8'hF0, 8'h20, 8'hF0},  // R6
        {2'd2, 2'd0, 8'h04, 8'h00, 8'h20, 8'hE0},  // R6
        {2'd2, 2'd0, 8'h21, 8'h01, 8'h24, 8'h22},  // R6
        {2'd2, 2'd0, 8'h67, 8'h01, 8'h2C, 8'h80}   // R5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_addr = '0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] byte_rdata;
    logic       reg_we = 1'b0;
    logic [2:0] reg_idx = '0;
    logic [1:0] bank_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bit_we = 1'b0;
    logic [7:0] bit_addr = '0;
    logic       bit_wval = 1'b0;
    logic       bit_rdata;
    logic [7:0] sfr_byte_addr;
    logic       sfr_byte_we;
    logic [7:0] sfr_byte_wdata;
    logic [7:0] sfr_byte_rdata;
    logic [7:0] sfr_bit_addr;
    logic       sfr_bit_we;
    logic [7:0] sfr_bit_wdata;
    logic [7:0] sfr_bit_rdata;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;
    logic dual_hit;
    logic [7:0] sfr_mem [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_bit_dmem uut (.*);

    // Simple model of the external register window.
    assign sfr_byte_rdata = sfr_mem[sfr_byte_addr[6:0]];
    assign sfr_bit_rdata  = sfr_mem[sfr_bit_addr[6:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 128; k++) sfr_mem[k] <= '0;
            dual_hit <= 1'b0;
        end else begin
            if (sfr_byte_we) sfr_mem[sfr_byte_addr[6:0]] <= sfr_byte_wdata;
            if (sfr_bit_we)  sfr_mem[sfr_bit_addr[6:0]]  <= sfr_bit_wdata;
            if (sfr_byte_we && sfr_bit_we && sfr_byte_addr == sfr_bit_addr)
                dual_hit <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd_byte(input logic [7:0] a, output logic [7:0] v);
        byte_addr = a;
        #1;
        v = byte_rdata;
    endtask

    task automatic apply(input logic [1:0] kind, input logic [1:0] bank,
                         input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        case (kind)
            2'd0: begin byte_we = 1'b1; byte_addr = a; byte_wdata = d; end
            2'd1: begin reg_we = 1'b1; bank_sel = bank; reg_idx = a[2:0]; reg_wdata = d; end
            default: begin bit_we = 1'b1; bit_addr = a; bit_wval = d[0]; end
        endcase
        @(negedge clk);
        byte_we = 1'b0;
        reg_we  = 1'b0;
        bit_we  = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every RAM byte is zero after reset.
        bad = 0;
        for (int a = 0; a < 128; a++) begin
            rd_byte(8'(a), v);
            if (v !== 8'h00) bad++;
        end
        chk("R1 reset zero count", 8'(bad), 8'h00);

        // Vector walk.
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][35:34], VEC[i][33:32], VEC[i][31:24], VEC[i][23:16]);
            rd_byte(VEC[i][15:8], v);
            chk($sformatf("R2/R3/R5/R6 vector %0d", i), v, VEC[i][7:0]);
        end

        // R3: register port reads bank 3 index 7.
        bank_sel = 2'd3; reg_idx = 3'd7; #1;
        chk("R3 reg read bank3 r7", reg_rdata, 8'h77);
        bank_sel = 2'd2; reg_idx = 3'd5; #1;
        chk("R3 reg read bank2 r5", reg_rdata, 8'h55);
        // R4: bank 0 register 2 equals byte 02h.
        bank_sel = 2'd0; reg_idx = 3'd2; #1;
        chk("R4 bank0 r2", reg_rdata, 8'h11);

        // R5: bit reads.
        bit_addr = 8'h25; #1;
        chk("R5 bit 25h read", {7'b0, bit_rdata}, 8'h01);
        bit_addr = 8'h26; #1;
        chk("R5 bit 26h read", {7'b0, bit_rdata}, 8'h00);

        // R6: byte 20h holds E0h, so bits 00h..07h read back its pattern.
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            bit_addr = 8'(k); #1;
            if (bit_rdata !== ((8'hE0 >> k) & 8'h01) != 8'h00) bad++;
        end
        chk("R6 bits of byte 20h", 8'(bad), 8'h00);

        // R7: window byte write and read, RAM byte 00h unaffected.
        apply(2'd0, 2'd0, 8'h80, 8'h5A);
        chk("R7 window stored", sfr_mem[0], 8'h5A);
        rd_byte(8'h80, v);
        chk("R7 window read", v, 8'h5A);
        rd_byte(8'h00, v);
        chk("R7 RAM 00h untouched", v, 8'h00);

        // R8: bit set 87h then clear 81h on register 80h.
        apply(2'd2, 2'd0, 8'h87, 8'h01);
        chk("R8 set bit 87h", sfr_mem[0], 8'hDA);
        bit_addr = 8'h87; #1;
        chk("R8 read bit 87h", {7'b0, bit_rdata}, 8'h01);
        apply(2'd2, 2'd0, 8'h81, 8'h00);
        chk("R8 clear bit 81h", sfr_mem[0], 8'hD8);
        apply(2'd2, 2'd0, 8'h8B, 8'h01);
        chk("R8 bit 8Bh in reg 88h", sfr_mem[8], 8'h08);

        // R9: byte 2Ah = 00h with bit 51h set in the same cycle.
        @(negedge clk);
        byte_we = 1'b1; byte_addr = 8'h2A; byte_wdata = 8'h00;
        bit_we = 1'b1; bit_addr = 8'h51; bit_wval = 1'b1;
        @(negedge clk);
        byte_we = 1'b0; bit_we = 1'b0;
        rd_byte(8'h2A, v);
        chk("R9 bit over byte", v, 8'h02);

        // R10: byte 05h = AAh with bank0 r5 = 33h in the same cycle.
        @(negedge clk);
        byte_we = 1'b1; byte_addr = 8'h05; byte_wdata = 8'hAA;
        reg_we = 1'b1; bank_sel = 2'd0; reg_idx = 3'd5; reg_wdata = 8'h33;
        @(negedge clk);
        byte_we = 1'b0; reg_we = 1'b0;
        rd_byte(8'h05, v);
        chk("R10 reg over byte", v, 8'h33);

        // R11: byte 90h = 0Fh with bit 97h set in the same cycle.
        @(negedge clk);
        byte_we = 1'b1; byte_addr = 8'h90; byte_wdata = 8'h0F;
        bit_we = 1'b1; bit_addr = 8'h97; bit_wval = 1'b1;
        @(negedge clk);
        byte_we = 1'b0; bit_we = 1'b0;
        chk("R11 window merged", sfr_mem[16], 8'h8F);
        chk("R11 single strobe", {7'b0, dual_hit}, 8'h00);

        // R1: reset in mid-run clears written bytes.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_byte(8'h30, v);
        chk("R1 reset clears 30h", v, 8'h00);
        rd_byte(8'h1F, v);
        chk("R1 reset clears 1Fh", v, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule